// File: doc/BRIEF.md
# Macro Result Dispatch and Method Writer

This block executes the result half of every instruction of a small command macro engine. A sequencer upstream decodes each instruction and computes its value. It then hands the block a request that holds a result mode, a destination register index and the computed value. Depending on the mode, the block does one or more of four things:
- writes the destination register,
- pops the next macro argument from an internal argument FIFO,
- reloads a combined method register,
- emits one method write (address, data) on a valid/ready output.

The method register holds a 12-bit target address and a 6-bit step. Each emitted write uses the current address, and the address then moves forward by the step, wrapping within 4096. Starting a macro pops the first argument straight into register 1 and clears everything else. Ending a macro with arguments still queued, or popping from an empty queue, raises a sticky error flag. The register file has a combinational read port, so the sequencer can fetch its operands.

Top module: `macro_result_dispatch`

## Requirements
- R1: After reset, req_ready is 1, mw_valid is 0, both error flags are 0 and every register reads 0.
- R2: A cycle with mac_start high pops the argument queue head into register 1. In the same cycle it zeroes all other registers, zeroes the method register (address and step) and clears both error flags.
- R3: Register 0 always reads 0, and a request that names it as destination leaves it unchanged.
- R4: req_mode codes are 0 fetch, 1 move, 2 move+load, 3 fetch+send, 4 move+send, 5 fetch+load, 6 move+load+send-popped-argument and 7 move+load+send-field. Codes 0, 3 and 5 write the popped argument to the destination. All other codes write the result. Codes 0, 3, 5 and 6 each pop exactly one argument.
- R5: Codes 2, 5, 6 and 7 load result bits 11:0 as the method address and bits 17:12 as the step, before any send of the same request.
- R6: Codes 3 and 4 send the result. Code 6 sends the popped argument. Code 7 sends result bits 17:12 zero-extended. Each send appears on mw_valid in the cycle after the request is accepted, with mw_addr equal to the method address in force for that request.
- R7: After each send, the method address increases by the step modulo 4096, and the step is kept.
- R8: While mw_valid is high, req_ready is low. mw_addr and mw_data hold steady until mw_ready is seen.
- R9: A pop from an empty queue sets err_underflow, which stays set until the next start. The destination then receives 0.
- R10: A cycle with mac_exit high while the queue is not empty sets err_leftover, which stays set until the next start. An exit on an empty queue leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prm_valid | input | 1 | Argument push strobe |
| prm_data | input | 32 | Argument value |
| prm_ready | output | 1 | Argument queue has room |
| mac_start | input | 1 | Begin a macro |
| mac_exit | input | 1 | Macro has finished |
| req_valid | input | 1 | Result request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_mode | input | 3 | Result mode code |
| req_dst | input | 3 | Destination register index |
| req_result | input | 32 | Computed value |
| rd_idx | input | 3 | Register read index |
| rd_data | output | 32 | Register read value |
| mw_valid | output | 1 | Method write pending |
| mw_ready | input | 1 | Consumer takes the write |
| mw_addr | output | 12 | Method write address |
| mw_data | output | 32 | Method write data |
| err_underflow | output | 1 | Sticky empty-pop flag |
| err_leftover | output | 1 | Sticky unconsumed-argument flag |

## Verification
Register writes, pops, method-register loads and flag updates all take effect at the edge that accepts the request or strobe. The bench therefore reads rd_data and the flags just after that edge. A send becomes visible on mw_valid one edge after acceptance and leaves at the first edge that sees mw_ready. A driver task computes each expected (address, data) pair from its own model of address and step, and queues it. A monitor compares queued pairs at falling edges whenever the handshake is about to complete. A held-off mw_ready window checks that the output stays stable and that requests are refused.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [2:0] {
    RM_FETCH         = 3'd0,
    RM_MOVE          = 3'd1,
    RM_MOVE_LOAD     = 3'd2,
    RM_FETCH_SEND    = 3'd3,
    RM_MOVE_SEND     = 3'd4,
    RM_FETCH_LOAD    = 3'd5,
    RM_MOVE_LOAD_ARG = 3'd6,
    RM_MOVE_LOAD_FLD = 3'd7
  } res_mode_e;

  typedef enum logic [1:0] {
    SS_RESULT = 2'd0,
    SS_ARG    = 2'd1,
    SS_FIELD  = 2'd2
  } send_src_e;

  typedef struct packed {
    logic      reg_from_arg;
    logic      pop;
    logic      load;
    logic      send;
    send_src_e src;
  } mode_ctl_t;

  function automatic mode_ctl_t decode_mode(input res_mode_e m);
    mode_ctl_t c;
    c = '{reg_from_arg: 1'b0, pop: 1'b0, load: 1'b0, send: 1'b0, src: SS_RESULT};
    case (m)
      RM_FETCH:         begin c.reg_from_arg = 1'b1; c.pop = 1'b1; end
      RM_MOVE:          ;
      RM_MOVE_LOAD:     c.load = 1'b1;
      RM_FETCH_SEND:    begin c.reg_from_arg = 1'b1; c.pop = 1'b1; c.send = 1'b1; end
      RM_MOVE_SEND:     c.send = 1'b1;
      RM_FETCH_LOAD:    begin c.reg_from_arg = 1'b1; c.pop = 1'b1; c.load = 1'b1; end
      RM_MOVE_LOAD_ARG: begin c.load = 1'b1; c.pop = 1'b1; c.send = 1'b1; c.src = SS_ARG; end
      RM_MOVE_LOAD_FLD: begin c.load = 1'b1; c.send = 1'b1; c.src = SS_FIELD; end
      default:          ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mrd_param_fifo.sv
module mrd_param_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (!do_push && do_pop) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R4
  fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/mrd_regfile.sv
module mrd_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] widx,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ridx,
  output logic [DW-1:0]           rdata
);
  localparam int RAW = $clog2(NREG);

  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (we && widx == RAW'(i)) rf[i] <= wdata;
        else if (clr)              rf[i] <= '0;
      end
    end
  end

  assign rdata = (ridx == '0) ? '0 : rf[ridx];

endmodule

// File: rtl/mrd_method_unit.sv
module mrd_method_unit #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int IW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic             load_en,
  input  logic [AW+IW-1:0] load_val,
  input  logic             send_en,
  input  logic [DW-1:0]    send_data,
  input  logic             mw_ready,
  output logic             mw_valid,
  output logic [AW-1:0]    mw_addr,
  output logic [DW-1:0]    mw_data,
  output logic             busy
);
  logic [AW-1:0] addr_q;
  logic [IW-1:0] step_q;
  logic [AW-1:0] eff_addr;
  logic [IW-1:0] eff_step;
  logic          send_evt;
  logic          drain_evt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a, input logic [IW-1:0] s);
    return a + AW'(s);
  endfunction

  assign eff_addr  = load_en ? load_val[AW-1:0]     : addr_q;
  assign eff_step  = load_en ? load_val[AW+IW-1:AW] : step_q;
  assign send_evt  = accept && send_en;
  assign drain_evt = mw_valid && mw_ready;
  assign busy      = mw_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (clr) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (accept && (load_en || send_en)) begin
      step_q <= eff_step;
      addr_q <= send_en ? bump(eff_addr, eff_step) : eff_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else if (send_evt) begin
      mw_valid <= 1'b1;
      mw_addr  <= eff_addr;
      mw_data  <= send_data;
    end else if (drain_evt) begin
      mw_valid <= 1'b0;
    end
  end

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  // R6
  send_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_evt |=> mw_valid);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_evt && !load_en && !clr) |=> (addr_q == $past(addr_q) + AW'($past(step_q))));

endmodule

// File: rtl/macro_result_dispatch.sv
module macro_result_dispatch
  import mrd_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NREG       = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int MADDR_W    = 12,
  parameter int MSTEP_W    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prm_valid,
  input  logic [DW-1:0]           prm_data,
  output logic                    prm_ready,
  input  logic                    mac_start,
  input  logic                    mac_exit,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_mode,
  input  logic [$clog2(NREG)-1:0] req_dst,
  input  logic [DW-1:0]           req_result,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0]           rd_data,
  output logic                    mw_valid,
  input  logic                    mw_ready,
  output logic [MADDR_W-1:0]      mw_addr,
  output logic [DW-1:0]           mw_data,
  output logic                    err_underflow,
  output logic                    err_leftover
);
  localparam int RAW = $clog2(NREG);
  localparam int MW  = MADDR_W + MSTEP_W;

  mode_ctl_t      ctl;
  logic           acc;
  logic           pop_req;
  logic           q_empty, q_full;
  logic [DW-1:0]  q_head, arg_val;
  logic           underflow_evt, leftover_evt;
  logic           busy;
  logic           rf_we;
  logic [RAW-1:0] rf_widx;
  logic [DW-1:0]  rf_wdata;
  logic [DW-1:0]  send_val;

  assign ctl       = decode_mode(res_mode_e'(req_mode));
  assign req_ready = !busy && !mac_start;
  assign acc       = req_valid && req_ready;
  assign prm_ready = !q_full;

  assign pop_req       = mac_start || (acc && ctl.pop);
  assign arg_val       = q_empty ? '0 : q_head;
  assign underflow_evt = pop_req && q_empty;
  assign leftover_evt  = mac_exit && !q_empty;

  assign rf_we    = mac_start || acc;
  assign rf_widx  = mac_start ? RAW'(1) : req_dst;
  assign rf_wdata = (mac_start || ctl.reg_from_arg) ? arg_val : req_result;

  always_comb begin
    case (ctl.src)
      SS_ARG:   send_val = arg_val;
      SS_FIELD: send_val = DW'(req_result[MW-1:MADDR_W]);
      default:  send_val = req_result;
    endcase
  end

  mrd_param_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(prm_valid), .push_data(prm_data),
    .pop(pop_req), .head(q_head),
    .empty(q_empty), .full(q_full)
  );

  mrd_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(mac_start),
    .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ridx(rd_idx), .rdata(rd_data)
  );

  mrd_method_unit #(.DW(DW), .AW(MADDR_W), .IW(MSTEP_W)) u_meth (
    .clk(clk), .rst_n(rst_n), .clr(mac_start),
    .accept(acc), .load_en(ctl.load), .load_val(req_result[MW-1:0]),
    .send_en(ctl.send), .send_data(send_val),
    .mw_ready(mw_ready), .mw_valid(mw_valid),
    .mw_addr(mw_addr), .mw_data(mw_data), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_underflow <= 1'b0;
      err_leftover  <= 1'b0;
    end else if (mac_start) begin
      err_underflow <= underflow_evt;
      err_leftover  <= 1'b0;
    end else begin
      err_underflow <= err_underflow | underflow_evt;
      err_leftover  <= err_leftover | leftover_evt;
    end
  end

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !req_ready);

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_underflow && !mac_start) |=> err_underflow);

  // R10
  leftover_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_leftover && !mac_start) |=> err_leftover);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_start && !q_empty) |=> (!err_underflow && !err_leftover));

endmodule

// File: tb/test_macro_result_dispatch.sv
module test_macro_result_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prm_valid = 1'b0;
  logic [31:0] prm_data = '0;
  logic        prm_ready;
  logic        mac_start = 1'b0;
  logic        mac_exit = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [2:0]  req_dst = '0;
  logic [31:0] req_result = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        mw_valid;
  logic        mw_ready = 1'b1;
  logic [11:0] mw_addr;
  logic [31:0] mw_data;
  logic        err_underflow, err_leftover;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit rdy_hold = 0;
  logic [11:0] m_addr = '0;
  logic [5:0]  m_step = '0;
  logic [43:0] expq [$];

  always #2 clk = ~clk;

  macro_result_dispatch i_macro_result_dispatch (
    .clk(clk), .rst_n(rst_n), .prm_valid(prm_valid), .prm_data(prm_data),
    .prm_ready(prm_ready), .mac_start(mac_start), .mac_exit(mac_exit),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_dst(req_dst), .req_result(req_result), .rd_idx(rd_idx),
    .rd_data(rd_data), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data), .err_underflow(err_underflow),
    .err_leftover(err_leftover)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_arg(input logic [31:0] v);
    prm_valid = 1'b1;
    prm_data  = v;
    tick();
    prm_valid = 1'b0;
  endtask

  task automatic pulse_start();
    mac_start = 1'b1;
    tick();
    mac_start = 1'b0;
  endtask

  task automatic pulse_exit();
    mac_exit = 1'b1;
    tick();
    mac_exit = 1'b0;
  endtask

  function automatic logic [31:0] rd(input int idx);
    return 32'(idx);
  endfunction

  // Driver: models the method register and queues expected writes.
  task automatic issue(input int mode, input int dst, input logic [31:0] res,
                       input logic [31:0] arg);
    bit ld, snd;
    logic [31:0] d;
    while (!req_ready) tick();
    req_valid  = 1'b1;
    req_mode   = 3'(mode);
    req_dst    = 3'(dst);
    req_result = res;
    ld  = (mode == 2 || mode == 5 || mode == 6 || mode == 7);
    snd = (mode == 3 || mode == 4 || mode == 6 || mode == 7);
    if (ld) begin
      m_addr = res[11:0];
      m_step = res[17:12];
    end
    if (snd) begin
      if (mode == 6)      d = arg;
      else if (mode == 7) d = {26'd0, res[17:12]};
      else                d = res;
      expq.push_back({m_addr, d});
      m_addr = m_addr + {6'd0, m_step};
    end
    tick();
    req_valid = 1'b0;
  endtask

  task automatic reg_is(input string tag, input int idx, input logic [31:0] exp);
    rd_idx = 3'(idx);
    #1;
    chk(tag, rd_data, exp);
  endtask

  // Ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      mw_ready = !rdy_hold;
    end
  end

  // Monitor: compare each completed write with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mw_valid && mw_ready) begin
        if (expq.size() == 0) begin
          chk("R6 unexpected write", {20'd0, mw_addr}, 32'hFFFF_FFFF);
        end else begin
          logic [43:0] e;
          e = expq.pop_front();
          chk("R6/R7 write addr", {20'd0, mw_addr}, {20'd0, e[43:32]});
          chk("R6 write data", mw_data, e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 mw_valid", {31'd0, mw_valid}, 32'd0);
    chk("R1 errors", {30'd0, err_underflow, err_leftover}, 32'd0);
    reg_is("R1 r1", 1, 32'd0);

    // R2 start with five arguments
    push_arg(32'hA000_0000);
    push_arg(32'hA000_0001);
    push_arg(32'hA000_0002);
    push_arg(32'hA000_0003);
    push_arg(32'hA000_0004);
    pulse_start();
    reg_is("R2 r1 first arg", 1, 32'hA000_0000);

    // R4 move and fetch
    issue(1, 2, 32'h0000_1234, 0);
    reg_is("R4 move r2", 2, 32'h0000_1234);
    issue(0, 3, 32'hFFFF_FFFF, 0);
    reg_is("R4 fetch r3", 3, 32'hA000_0001);

    // R3 register zero
    issue(1, 0, 32'hDEAD_BEEF, 0);
    reg_is("R3 r0 zero", 0, 32'd0);

    // R5 load without send: step 2, address 0xFFE
    issue(2, 4, 32'h0000_2FFE, 0);
    reg_is("R5 r4", 4, 32'h0000_2FFE);
    chk("R5 no send", {31'd0, mw_valid}, 32'd0);

    // R8 stall: hold ready low during a move+send
    rdy_hold = 1;
    @(negedge clk);
    issue(4, 5, 32'hAAAA_5555, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 valid held", {31'd0, mw_valid}, 32'd1);
      chk("R8 ready low", {31'd0, req_ready}, 32'd0);
      chk("R8 data held", mw_data, 32'hAAAA_5555);
    end
    rdy_hold = 0;

    // R7 wrap: next address is 0x000
    issue(4, 5, 32'h0000_0011, 0);
    reg_is("R4 move+send r5", 5, 32'h0000_0011);

    // R6 fetch+send
    issue(3, 5, 32'h0000_0077, 0);
    reg_is("R4 fetch+send r5", 5, 32'hA000_0002);

    // R5 fetch+load
    issue(5, 6, 32'h0000_1100, 0);
    reg_is("R4 fetch+load r6", 6, 32'hA000_0003);

    // R6 send popped argument
    issue(6, 7, 32'h0000_3200, 32'hA000_0004);
    reg_is("R4 move+load+arg r7", 7, 32'h0000_3200);

    // R6 send field 17:12
    issue(7, 1, 32'h0002_A010, 0);
    reg_is("R4 move+load+field r1", 1, 32'h0002_A010);

    // R7 step kept after a field send: base 0x010 step 0x2A -> next 0x03A
    issue(4, 2, 32'h0000_0042, 0);

    // R10 exit on empty queue
    pulse_exit();
    chk("R10 no leftover", {31'd0, err_leftover}, 32'd0);

    // R9 fetch from empty queue
    issue(0, 2, 32'h1111_1111, 0);
    reg_is("R9 zero written", 2, 32'd0);
    chk("R9 underflow", {31'd0, err_underflow}, 32'd1);
    issue(1, 3, 32'h5, 0);
    chk("R9 sticky", {31'd0, err_underflow}, 32'd1);

    // R2 restart clears
    push_arg(32'hB000_0000);
    push_arg(32'hB000_0001);
    push_arg(32'hB000_0002);
    pulse_start();
    m_addr = '0;
    m_step = '0;
    chk("R2 errors cleared", {30'd0, err_underflow, err_leftover}, 32'd0);
    reg_is("R2 r1 new", 1, 32'hB000_0000);
    reg_is("R2 r3 cleared", 3, 32'd0);

    // R2 method register cleared: send goes to address 0
    issue(4, 4, 32'h0000_0099, 0);

    // R10 exit with leftovers
    pulse_exit();
    chk("R10 leftover", {31'd0, err_leftover}, 32'd1);
    tick();
    chk("R10 sticky", {31'd0, err_leftover}, 32'd1);

    repeat (5) tick();
    chk("R6 all writes seen", 32'(expq.size()), 32'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule